// File: doc/BRIEF.md
# General-Purpose I/O Port with Masked Pattern-Match Event

This block is one 8-bit general-purpose I/O port for a small register bus. Software writes an output latch that sets each pin's drive. Each pin drives either push-pull or open-drain, chosen bit by bit. A read of the port returns one of two values. A plain read returns the synchronized pin levels, and pins configured as analog read as zero. A read that is the read phase of a read-modify-write returns the latch, so bit operations never copy an external pin level into the latch.

The block also compares the synchronized pins against a match register under a mask. The match event is raised while any unmasked pin differs from its match bit. The event drives a wake output at all times. It drives the interrupt request only while the interrupt enable is set. Pin inputs pass through a two-flop synchronizer before they reach the read path or the comparator. The mask and match registers reset to zero, so no event is present after reset.

Top module: `gpio_match_port`

## Requirements
- R1: When `latch_we` is high at a rising clock edge, `wr_data` is stored in the output latch, and `pad_out` shows it from that edge on.
- R2: During and after reset, the latch reads 0xFF and `match_evt`, `irq` and `wake` are all 0, because mask and match both reset to 0x00.
- R3: When `rd_rmw` is 0, `rd_data` returns the synchronized pin levels.
- R4: When `rd_rmw` is 1, `rd_data` returns the output latch, whatever the pin levels and analog settings are.
- R5: On a plain read, each bit whose `analog_sel` bit is 1 reads as 0.
- R6: A bit whose `pushpull` bit is 1 always has `pad_oe` = 1, and drives the latch value.
- R7: A bit whose `pushpull` bit is 0 (open-drain) has `pad_oe` = 1 only when its latch bit is 0. With its latch bit at 1 it is high-impedance.
- R8: `match_evt` is 1 exactly when ((pins AND mask) != (match AND mask)). Pins whose mask bit is 0 have no effect on it. `mask_we` and `match_we` load `wr_data` into the mask and match registers at the clock edge.
- R9: `irq` equals `match_evt` AND `int_en`. It is a level that clears once the masked pins equal the masked match value again.
- R10: `wake` follows `match_evt` regardless of `int_en`.
- R11: A change on `pin_in` reaches `rd_data` and `match_evt` after exactly two rising edges. After one edge, the old value is still seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| latch_we | input | 1 | Write strobe for the output latch |
| mask_we | input | 1 | Write strobe for the mask register |
| match_we | input | 1 | Write strobe for the match register |
| wr_data | input | WIDTH | Write data shared by all registers |
| rd_rmw | input | 1 | 1 = read phase of a read-modify-write (return the latch) |
| rd_data | output | WIDTH | Port read value |
| pin_in | input | WIDTH | Asynchronous pin levels |
| analog_sel | input | WIDTH | Per-bit analog configuration (1 = analog) |
| pushpull | input | WIDTH | Per-bit output mode (1 = push-pull, 0 = open-drain) |
| int_en | input | 1 | Interrupt enable for the match event |
| pad_out | output | WIDTH | Per-bit pad output value |
| pad_oe | output | WIDTH | Per-bit pad output enable |
| match_evt | output | 1 | Masked mismatch event |
| irq | output | 1 | Interrupt request (level) |
| wake | output | 1 | Wake request from the match event |

## Verification
The read path is tried with the latch and the pins held at different values, so a plain read and a read-modify-write read give different answers. Analog masking is applied on top of that to show it affects only pin reads. For the comparator, the masked pins are first set equal to the masked match value and then made unequal. A masked-off pin is toggled to show it is ignored. Each pin step is sampled after one edge and again after two, which separates a correct two-flop synchronizer from one that is too short or too long. The interrupt enable is toggled while the event is held, which separates `irq` from `wake`.

// File: rtl/gpio_match_port.sv
module gpio_match_port #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_we,
  input  logic             mask_we,
  input  logic             match_we,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_rmw,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] analog_sel,
  input  logic [WIDTH-1:0] pushpull,
  input  logic             int_en,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic             match_evt,
  output logic             irq,
  output logic             wake
);

  localparam logic [WIDTH-1:0] LATCH_RST = '1;

  logic [WIDTH-1:0] latch_q, mask_q, match_q, sync1_q, sync2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= LATCH_RST;
      mask_q  <= '0;
      match_q <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      if (latch_we) latch_q <= wr_data;
      if (mask_we)  mask_q  <= wr_data;
      if (match_we) match_q <= wr_data;
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  assign rd_data   = rd_rmw ? latch_q : (sync2_q & ~analog_sel);
  assign pad_out   = latch_q;
  assign pad_oe    = pushpull | ~latch_q;
  assign match_evt = |((sync2_q ^ match_q) & mask_q);
  assign wake      = match_evt;
  assign irq       = match_evt & int_en;

  // R1
  latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_we |=> pad_out == $past(wr_data));

  // R4
  rmw_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rmw |-> rd_data == pad_out);

  // R5
  analog_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rmw |-> (rd_data & analog_sel) == '0);

  // R7
  open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~pushpull & pad_out) == '0);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (wake && int_en));

  // R10
  wake_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt == wake);

endmodule

// File: tb/tb_gpio_match_port.sv
module tb_gpio_match_port;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       latch_we = 0, mask_we = 0, match_we = 0, rd_rmw = 0, int_en = 0;
  logic [7:0] wr_data = 0, pin_in = 8'hA5, analog_sel = 0, pushpull = 0;
  logic [7:0] rd_data, pad_out, pad_oe;
  logic       match_evt, irq, wake;

  int vectors = 0, miscompares = 0, cycles = 0;
  int    q_sel[$];
  logic [7:0] q_exp[$];
  string q_req[$];

  always #4 clk = ~clk;

  gpio_match_port dut (
    .clk(clk), .rst_n(rst_n), .latch_we(latch_we), .mask_we(mask_we),
    .match_we(match_we), .wr_data(wr_data), .rd_rmw(rd_rmw), .rd_data(rd_data),
    .pin_in(pin_in), .analog_sel(analog_sel), .pushpull(pushpull), .int_en(int_en),
    .pad_out(pad_out), .pad_oe(pad_oe), .match_evt(match_evt), .irq(irq), .wake(wake)
  );

  // sel: 0 rd_data, 1 pad_out, 2 pad_oe, 3 {wake,irq,match_evt}
  task automatic expect_item(input int sel, input logic [7:0] exp, input string req);
    q_sel.push_back(sel); q_exp.push_back(exp); q_req.push_back(req);
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic write_reg(input int which, input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    latch_we = (which == 0); mask_we = (which == 1); match_we = (which == 2);
    @(negedge clk);
    latch_we = 0; mask_we = 0; match_we = 0;
    #1;
  endtask

  always @(negedge clk) begin
    while (q_sel.size() > 0) begin
      int s; logic [7:0] e, a; string r;
      s = q_sel.pop_front(); e = q_exp.pop_front(); r = q_req.pop_front();
      case (s)
        0: a = rd_data;
        1: a = pad_out;
        2: a = pad_oe;
        default: a = {5'b0, wake, irq, match_evt};
      endcase
      vectors++;
      if (a !== e) begin
        miscompares++;
        $display("FAIL %s sel=%0d actual=%02h expected=%02h", r, s, a, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    expect_item(1, 8'hFF, "R2");
    expect_item(3, 8'h00, "R2");
    expect_item(2, 8'h00, "R7");
    @(negedge clk); rst_n = 1;
    step(); step(); step();
    expect_item(0, 8'hA5, "R3");
    @(negedge clk); pin_in = 8'h3C; #1;
    expect_item(0, 8'hA5, "R11 one edge");
    step();
    expect_item(0, 8'h3C, "R11 two edges");
    step();
    analog_sel = 8'h0F; #1;
    expect_item(0, 8'h30, "R5");
    step();
    rd_rmw = 1; #1;
    expect_item(0, 8'hFF, "R4");
    step();
    write_reg(0, 8'h5A);
    expect_item(1, 8'h5A, "R1");
    expect_item(0, 8'h5A, "R4 latch");
    expect_item(2, 8'hA5, "R7");
    step();
    pushpull = 8'hF0; #1;
    expect_item(2, 8'hF5, "R6 mixed");
    step();
    pushpull = 8'hFF; #1;
    expect_item(2, 8'hFF, "R6");
    step();
    rd_rmw = 0; analog_sel = 0;
    write_reg(1, 8'h0F);
    write_reg(2, 8'h0C);
    expect_item(3, 8'h00, "R8 equal");
    step();
    write_reg(2, 8'h0D);
    expect_item(3, 8'h05, "R8 R10 differ");
    step();
    int_en = 1; #1;
    expect_item(3, 8'h07, "R9 enabled");
    step();
    @(negedge clk); pin_in = 8'h3D; #1;
    expect_item(3, 8'h07, "R11 match one edge");
    step();
    expect_item(3, 8'h00, "R9 clears");
    step();
    @(negedge clk); pin_in = 8'hBD; #1;
    step(); step();
    expect_item(3, 8'h00, "R8 masked bit ignored");
    step();
    @(negedge clk); pin_in = 8'hBC; #1;
    step(); step();
    expect_item(3, 8'h07, "R8 R9 mismatch again");
    step();
    int_en = 0; #1;
    expect_item(3, 8'h05, "R10 wake without enable");
    step(); step();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule